// File: doc/BRIEF.md
# Multiplexed 8-bit Parallel Write Sequencer

This block turns one 32-bit write request into the strobe and bus sequence that an asynchronous 8-bit memory, or a memory-mapped peripheral, expects on a port where address and data share the same pins. Each request opens with an address-latch phase. During that phase the full 16-bit start address is driven on the upper and lower bus halves. After the latch phase the block performs exactly four byte writes. Bytes go out least significant first, and the address advances by one for every byte.

The strobe timing can be stretched per request by three settings: a 5-bit duration field, an optional one-clock hold cycle, and a flash mode that adds a seven-clock penalty. All settings are captured at the moment a request is accepted. The latch-strobe polarity is taken live from its input and must only change while the block is idle. A request is taken only while the block is idle. A one-cycle done pulse marks the end of the burst.

Top module: `mux8_wr_seq`

## Requirements
- R1: `startReq` is accepted only while `busy` is low; `busy` is high from the clock after acceptance until the burst returns to idle, and a request raised while busy starts no further burst.
- R2: The latch strobe is active for exactly 2 clocks, with the start address on {`busHi`,`busLo`} in both cycles and for 1 further clock after it goes inactive.
- R3: With `latchPolLow` = 0 the latch strobe is active high, with `latchPolLow` = 1 it is active low; outside the latch phase `addrLatch` equals `latchPolLow`.
- R4: `wrStrobeN` first falls after exactly 2 clocks in which the latch strobe is inactive.
- R5: Each latch phase is followed by exactly four write strobes. Byte k (k = 0..3) carries `wordIn[8k+7:8k]` on `busLo` for the whole low period, and the upper byte of (start address + k) modulo 2^16 on `busHi`, which is already valid 1 clock before the strobe falls.
- R6: The write strobe stays low for D - F clocks, where D is `durCfg` (0 is taken as 1) and F is 7 in flash mode and 0 otherwise.
- R7: In flash mode a duration field below 9 is raised to 9, so the low width is at least 2 clocks.
- R8: Between one write strobe rising and the next falling there are exactly F + H + 1 clocks, where H is 1 when `holdEn` is set and 0 otherwise.
- R9: With `holdEn` set, `busHi` and `busLo` keep the previous byte's values for 1 clock after each write strobe rises.
- R10: `done` is high for one clock, H clocks after the last write strobe rises, and `busy` is low in the following clock.
- R11: During and after reset `wrStrobeN` is high, the latch strobe is inactive, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Request a four-byte burst (taken while idle) |
| wordIn | input | 32 | Data word, byte 0 in bits 7:0 |
| addrIn | input | 16 | Start byte address |
| durCfg | input | 5 | Data cycle duration in clocks |
| holdEn | input | 1 | Add one hold clock after each write strobe |
| flashEn | input | 1 | Flash mode: 7-clock penalty, duration at least 9 |
| latchPolLow | input | 1 | Latch strobe active low when set |
| addrLatch | output | 1 | Address latch strobe |
| wrStrobeN | output | 1 | Write strobe, active low |
| busHi | output | 8 | Upper multiplexed bus half |
| busLo | output | 8 | Lower multiplexed bus half |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |

## Verification
The hardest case to reach is a flash-mode burst whose duration field is below the minimum. The clamp, the penalty and the hold cycle all act together, and a wrong choice of clamp only shows up as an off-by-some low width or gap. The bench drives a flash request with a small duration and the hold cycle enabled, and a second flash request with a large duration and no hold. It also runs a burst whose start address wraps past 0xFFFF, and it raises a second request mid-burst with a different address to show that the request is dropped.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
  localparam int BURST = 4;
  localparam int BYTE_W = 8;
  localparam int IDX_W = $clog2(BURST);

  typedef enum logic [2:0] {
    S_IDLE, S_LATCH, S_SETTLE, S_STROBE, S_GAP, S_TAIL, S_DONE
  } seqState_t;

  typedef struct packed {
    logic             load;
    logic             latchOn;
    logic             wrOn;
    logic             addrPhase;
    logic             bytePhase;
    logic [IDX_W-1:0] byteSel;
    logic             done;
    logic             busy;
  } strobe_t;
endpackage

// File: rtl/wseq_ctrl.sv
module wseq_ctrl
  import wseq_pkg::*;
#(
  parameter int DUR_W      = 5,
  parameter int LATCH_CYC  = 2,
  parameter int SETTLE_CYC = 2,
  parameter int FLASH_PEN  = 7,
  parameter int FLASH_MIN  = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [DUR_W-1:0] durCfg,
  input  logic             holdEn,
  input  logic             flashEn,
  output strobe_t          stb
);
  localparam int CNT_W = DUR_W + 1;

  seqState_t        state;
  logic [CNT_W-1:0] cnt, wLen, gLen, penReg;
  logic [CNT_W-1:0] durBase, durEff, penNow;
  logic             holdReg;
  logic [IDX_W-1:0] idx;
  logic             lastCyc;

  // effective duration and per-request lengths
  always_comb begin
    durBase = (durCfg == '0) ? CNT_W'(1) : CNT_W'(durCfg);
    durEff  = (flashEn && durBase < CNT_W'(FLASH_MIN)) ? CNT_W'(FLASH_MIN) : durBase;
    penNow  = flashEn ? CNT_W'(FLASH_PEN) : '0;
  end

  assign lastCyc = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      idx     <= '0;
      wLen    <= CNT_W'(1);
      gLen    <= CNT_W'(1);
      penReg  <= '0;
      holdReg <= 1'b0;
    end else begin
      if (!lastCyc) cnt <= cnt - CNT_W'(1);
      case (state)
        S_IDLE: if (startReq) begin
          state   <= S_LATCH;
          cnt     <= CNT_W'(LATCH_CYC - 1);
          idx     <= '0;
          wLen    <= durEff - penNow;
          gLen    <= penNow + CNT_W'(holdEn) + CNT_W'(1);
          penReg  <= penNow;
          holdReg <= holdEn;
        end
        S_LATCH: if (lastCyc) begin
          state <= S_SETTLE;
          cnt   <= CNT_W'(SETTLE_CYC - 1);
        end
        S_SETTLE: if (lastCyc) begin
          state <= S_STROBE;
          cnt   <= wLen - CNT_W'(1);
        end
        S_STROBE: if (lastCyc) begin
          if (idx == IDX_W'(BURST - 1)) begin
            state <= holdReg ? S_TAIL : S_DONE;
            cnt   <= '0;
          end else begin
            state <= S_GAP;
            cnt   <= gLen - CNT_W'(1);
          end
        end
        S_GAP: if (lastCyc) begin
          state <= S_STROBE;
          cnt   <= wLen - CNT_W'(1);
          idx   <= idx + IDX_W'(1);
        end
        S_TAIL: if (lastCyc) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.busy      = (state != S_IDLE);
    stb.load      = (state == S_IDLE) && startReq;
    stb.latchOn   = (state == S_LATCH);
    stb.wrOn      = (state == S_STROBE);
    stb.addrPhase = (state == S_LATCH) || (state == S_SETTLE && !lastCyc);
    stb.bytePhase = (state == S_SETTLE && lastCyc) || (state == S_STROBE) ||
                    (state == S_GAP) || (state == S_TAIL);
    // after the hold window of a gap the next byte is presented
    stb.byteSel   = idx + IDX_W'(state == S_GAP && cnt <= penReg);
    stb.done      = (state == S_DONE);
  end
endmodule

// File: rtl/wseq_dp.sv
module wseq_dp
  import wseq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic [BURST*BYTE_W-1:0]  wordIn,
  input  logic [ADDR_W-1:0]        addrIn,
  input  logic                     latchPolLow,
  output logic                     addrLatch,
  output logic                     wrStrobeN,
  output logic [ADDR_W-BYTE_W-1:0] busHi,
  output logic [BYTE_W-1:0]        busLo
);
  logic [BURST*BYTE_W-1:0] wordReg;
  logic [ADDR_W-1:0]       addrReg, byteAddr;
  logic [BYTE_W-1:0]       lane [BURST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg <= '0;
      addrReg <= '0;
    end else if (stb.load) begin
      wordReg <= wordIn;
      addrReg <= addrIn;
    end
  end

  for (genvar g = 0; g < BURST; g++) begin : g_lane
    assign lane[g] = wordReg[g*BYTE_W +: BYTE_W];
  end

  assign byteAddr = addrReg + ADDR_W'(stb.byteSel);

  always_comb begin
    busHi = '0;
    busLo = '0;
    if (stb.addrPhase) begin
      busHi = addrReg[ADDR_W-1:BYTE_W];
      busLo = addrReg[BYTE_W-1:0];
    end else if (stb.bytePhase) begin
      busHi = byteAddr[ADDR_W-1:BYTE_W];
      busLo = lane[stb.byteSel];
    end
  end

  assign addrLatch = stb.latchOn ^ latchPolLow;
  assign wrStrobeN = ~stb.wrOn;
endmodule

// File: rtl/mux8_wr_seq.sv
module mux8_wr_seq
  import wseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DUR_W      = 5,
  parameter int LATCH_CYC  = 2,
  parameter int SETTLE_CYC = 2,
  parameter int FLASH_PEN  = 7,
  parameter int FLASH_MIN  = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startReq,
  input  logic [BURST*BYTE_W-1:0]  wordIn,
  input  logic [ADDR_W-1:0]        addrIn,
  input  logic [DUR_W-1:0]         durCfg,
  input  logic                     holdEn,
  input  logic                     flashEn,
  input  logic                     latchPolLow,
  output logic                     addrLatch,
  output logic                     wrStrobeN,
  output logic [ADDR_W-BYTE_W-1:0] busHi,
  output logic [BYTE_W-1:0]        busLo,
  output logic                     busy,
  output logic                     done
);
  strobe_t stb;

  wseq_ctrl #(
    .DUR_W(DUR_W), .LATCH_CYC(LATCH_CYC), .SETTLE_CYC(SETTLE_CYC),
    .FLASH_PEN(FLASH_PEN), .FLASH_MIN(FLASH_MIN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .durCfg(durCfg),
    .holdEn(holdEn), .flashEn(flashEn), .stb(stb)
  );

  wseq_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wordIn(wordIn), .addrIn(addrIn),
    .latchPolLow(latchPolLow), .addrLatch(addrLatch), .wrStrobeN(wrStrobeN),
    .busHi(busHi), .busLo(busLo)
  );

  assign busy = stb.busy;
  assign done = stb.done;
endmodule

// File: rtl/wseq_chk.sv
module wseq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       startReq,
  input logic       latchPolLow,
  input logic       addrLatch,
  input logic       wrStrobeN,
  input logic [7:0] busHi,
  input logic [7:0] busLo,
  input logic       busy,
  input logic       done
);
  p_start_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq));

  p_latch_vs_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobeN |-> (addrLatch == latchPolLow));

  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (addrLatch == latchPolLow) && wrStrobeN);

  p_hi_setup_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrStrobeN) |-> $stable(busHi));

  p_lo_steady_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!wrStrobeN && !$past(wrStrobeN)) |-> $stable(busLo));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);

  p_done_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy && wrStrobeN);
endmodule

bind mux8_wr_seq wseq_chk u_wseq_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .latchPolLow(latchPolLow),
  .addrLatch(addrLatch), .wrStrobeN(wrStrobeN), .busHi(busHi), .busLo(busLo),
  .busy(busy), .done(done)
);

// File: tb/test_mux8_wr_seq.sv
module test_mux8_wr_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [31:0] wordIn = '0;
  logic [15:0] addrIn = '0;
  logic [4:0]  durCfg = '0;
  logic        holdEn = 1'b0, flashEn = 1'b0, latchPolLow = 1'b0;
  logic        addrLatch, wrStrobeN, busy, done;
  logic [7:0]  busHi, busLo;

  mux8_wr_seq i_mux8_wr_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .wordIn(wordIn), .addrIn(addrIn),
    .durCfg(durCfg), .holdEn(holdEn), .flashEn(flashEn), .latchPolLow(latchPolLow),
    .addrLatch(addrLatch), .wrStrobeN(wrStrobeN), .busHi(busHi), .busLo(busLo),
    .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit         isLatch;
    logic [7:0] hi, lo;
    int         width, lead;
    bit         hold, flash, first, last;
  } item_t;

  item_t expQ[$];
  item_t cur;
  int checks = 0, fails = 0, doneCnt = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // monitor: samples at the falling edge and pops expected items
  bit prevAct = 0, prevWr = 1, tailArm = 0;
  int latchLen = 0, lowLen = 0, gapCnt = 0;
  logic [7:0] prevHi = '0;
  always @(negedge clk) if (rstN) begin
    bit act;
    act = addrLatch ^ latchPolLow;
    if (act) begin
      if (!prevAct) begin
        latchLen = 0;
        if (expQ.size() == 0) chk(0, "R1", "latch phase without request", 1, 0);
        else begin
          cur = expQ.pop_front();
          chk(cur.isLatch, "R5", "latch phase order", 0, 1);
        end
      end
      latchLen++;
      chk({busHi, busLo} == {cur.hi, cur.lo}, "R2", "address in latch", {busHi, busLo}, {cur.hi, cur.lo});
      gapCnt = 0;
    end else if (prevAct) begin
      chk(latchLen == 2, "R2", "latch width", latchLen, 2);
      chk({busHi, busLo} == {cur.hi, cur.lo}, "R2", "address hold", {busHi, busLo}, {cur.hi, cur.lo});
    end
    if (!wrStrobeN) begin
      if (prevWr) begin
        if (expQ.size() == 0) chk(0, "R5", "extra write strobe", 1, 0);
        else begin
          cur = expQ.pop_front();
          chk(!cur.isLatch, "R5", "write strobe order", 1, 0);
          chk(gapCnt == cur.lead, cur.first ? "R4" : "R8", "clocks before strobe", gapCnt, cur.lead);
          chk(prevHi == cur.hi, "R5", "upper address setup", prevHi, cur.hi);
        end
        lowLen = 0;
      end
      chk(busHi == cur.hi, "R5", "upper address", busHi, cur.hi);
      chk(busLo == cur.lo, "R5", "data byte", busLo, cur.lo);
      lowLen++;
      gapCnt = 0;
    end else if (!prevWr) begin
      chk(lowLen == cur.width, cur.flash ? "R7" : "R6", "strobe low width", lowLen, cur.width);
      if (cur.hold)
        chk({busHi, busLo} == {cur.hi, cur.lo}, "R9", "hold after strobe", {busHi, busLo}, {cur.hi, cur.lo});
      if (cur.last) tailArm = 1;
    end
    if (done) begin
      chk(tailArm, "R10", "done after last strobe", 0, 1);
      chk(gapCnt == (cur.hold ? 1 : 0), "R10", "done delay", gapCnt, cur.hold ? 1 : 0);
      tailArm = 0;
      doneCnt++;
    end
    if (!act && wrStrobeN) gapCnt++;
    prevHi  = busHi;
    prevAct = act;
    prevWr  = wrStrobeN;
  end

  // driver: pushes expected items and starts one burst
  task automatic burst(logic [15:0] a, logic [31:0] w, logic [4:0] d, bit h, bit f, bit pol, bit intrude);
    item_t it;
    int de, wl, gl, d0;
    de = (d == 0) ? 1 : d;
    if (f && de < 9) de = 9;
    wl = de - (f ? 7 : 0);
    gl = (f ? 7 : 0) + h + 1;
    d0 = doneCnt;
    latchPolLow = pol;
    @(negedge clk);
    chk(addrLatch == pol, "R3", "idle latch level", addrLatch, pol);
    it = '{isLatch: 1, hi: a[15:8], lo: a[7:0], width: 2, lead: 0,
           hold: 0, flash: 0, first: 0, last: 0};
    expQ.push_back(it);
    for (int k = 0; k < 4; k++) begin
      logic [15:0] ba;
      ba = a + 16'(k);
      it = '{isLatch: 0, hi: ba[15:8], lo: w[8*k +: 8], width: wl,
             lead: (k == 0) ? 2 : gl, hold: h, flash: f, first: (k == 0), last: (k == 3)};
      expQ.push_back(it);
    end
    @(posedge clk); #1;
    addrIn = a; wordIn = w; durCfg = d; holdEn = h; flashEn = f; startReq = 1;
    @(posedge clk); #1;
    startReq = 0;
    chk(busy, "R1", "busy after accept", busy, 1);
    if (intrude) begin
      repeat (5) @(posedge clk);
      #1 startReq = 1; addrIn = ~a; wordIn = ~w;
      repeat (3) @(posedge clk);
      #1 startReq = 0;
    end
    while (busy) @(posedge clk);
    #1;
    chk(doneCnt == d0 + 1, "R10", "one done pulse", doneCnt - d0, 1);
    chk(expQ.size() == 0, "R5", "four strobes per latch", expQ.size(), 0);
    repeat (12) @(posedge clk);
    #1;
    chk(!busy, "R1", "no second burst", busy, 0);
    chk(doneCnt == d0 + 1, "R1", "no extra done", doneCnt - d0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(wrStrobeN == 1, "R11", "reset strobe", wrStrobeN, 1);
    chk(addrLatch == 0, "R11", "reset latch", addrLatch, 0);
    chk(!busy && !done, "R11", "reset busy/done", {busy, done}, 0);
    rstN = 1;
    @(negedge clk);
    chk(wrStrobeN == 1 && !busy, "R11", "after reset", {wrStrobeN, busy}, 2);
    burst(16'h1234, 32'hA1B2C3D4, 5'd4, 0, 0, 0, 0);
    burst(16'h0A10, 32'h11223344, 5'd0, 1, 0, 0, 0);
    burst(16'h8000, 32'h55667788, 5'd3, 1, 1, 0, 0);
    burst(16'h4321, 32'hCAFEF00D, 5'd12, 0, 1, 0, 0);
    burst(16'hFFFE, 32'h0F1E2D3C, 5'd31, 0, 0, 1, 0);
    burst(16'h00FF, 32'hDEADBEEF, 5'd2, 1, 0, 1, 1);
    latchPolLow = 0;
    repeat (2) @(negedge clk);
    chk(addrLatch == 0, "R3", "idle level after polarity back", addrLatch, 0);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", "run timed out", 0, 1);
    summary();
  end
endmodule